// File: doc/BRIEF.md
# Threshold-Gated Top Interrupt Selector

This block serves one interrupt file of a message-driven interrupt controller. It takes a vector of pending bits and a vector of enable bits, one pair for each interrupt identity. It picks the lowest-numbered identity whose two bits are both set and reports it as the top interrupt. A programmable threshold can narrow the search so that only identities below a chosen value compete. A delivery-enable bit gates the external interrupt request line that leaves the block.

Software reaches three registers through a narrow access port: the delivery-enable register, the threshold register, and the top-interrupt register. A write to the top-interrupt register is a claim. It stores nothing. Instead, it emits a one-cycle clear strobe that carries the identity of the current winner, so that the pending-bit storage outside the block can drop that bit. Pending and enable storage and the bus address decode sit outside this block.

Top module: `irq_top_sel`

## Requirements
- R1: Identity 0 never wins, even when its pending and enable bits are both set; the search runs from identity 1 up to NUM_IDS-1.
- R2: An identity qualifies only when its pending bit and its enable bit are both 1; among qualifying identities the lowest number wins.
- R3: When the threshold is nonzero and at most NUM_IDS, only identities strictly below the threshold can win.
- R4: When the threshold is 0, or is larger than NUM_IDS, every implemented identity can win.
- R5: `top_o` carries the winning identity in bits 10:0 and again in bits 26:16, with all other bits zero; it is all zero when no identity qualifies.
- R6: Access select code 2 (top register) with `acc_wr_i` high and a nonzero `acc_wmask_i` raises `clr_vld_o` in that same cycle, with `clr_id_o` equal to the current winner; `acc_wdata_i` has no effect on the strobe.
- R7: A top-register write with an all-zero mask, or any top-register write while nothing qualifies, leaves `clr_vld_o` low.
- R8: `irq_o` is registered and equals, one cycle later, delivery-enable bit 0 AND a nonzero top value.
- R9: Select code 0 is the delivery-enable register: only bit 0 holds state, each bit updates only where its mask bit is 1, and `acc_rdata_o` shows the value held before the write.
- R10: Select code 1 is the threshold register: only bits 10:0 hold state, the write is masked per bit, and `acc_rdata_o` shows the value held before the write.
- R11: Reset clears delivery-enable and threshold and drives `irq_o` low; select code 3 reads as zero and writes to it have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| pend_i | input | NUM_IDS | Pending bit per identity |
| enab_i | input | NUM_IDS | Enable bit per identity |
| acc_sel_i | input | 2 | Register select: 0 delivery, 1 threshold, 2 top, 3 idle |
| acc_wr_i | input | 1 | Write strobe for the selected register |
| acc_wdata_i | input | 32 | Write data |
| acc_wmask_i | input | 32 | Per-bit write mask |
| acc_rdata_o | output | 32 | Value of the selected register before any write in this cycle |
| top_o | output | 32 | Top-interrupt value |
| clr_vld_o | output | 1 | Claim clear strobe |
| clr_id_o | output | 11 | Identity whose pending bit must be cleared |
| irq_o | output | 1 | External interrupt request line |

## Verification
The selector sees pending-only, enable-only and overlapping patterns. These show that an identity needs both bits to qualify and that the lowest one wins over higher ones. Identity 0 appears alone and with every bit set, which confirms that it is skipped. The threshold is set just below, at and just above a qualifying identity, to the identity count, to zero and beyond the count. This sets the strict cutoff apart from the cases that search everything. Claims are issued with zero and nonzero masks and with different data, and with and without a winner. The request line is sampled in the cycle after each change, which separates its registered timing from the combinational top value.

// File: rtl/tsel_pkg.sv
package tsel_pkg;
    localparam int DATA_W   = 32;
    localparam int ID_W     = 11;
    localparam int PRIO_LSB = 16;

    typedef enum logic [1:0] {
        SEL_DLV  = 2'd0,
        SEL_THR  = 2'd1,
        SEL_TOP  = 2'd2,
        SEL_IDLE = 2'd3
    } acc_sel_e;

    typedef struct packed {
        logic            dlv;
        logic [ID_W-1:0] thr;
        logic            irq;
    } sel_state_t;
endpackage

// File: rtl/tsel_qual.sv
module tsel_qual #(
    parameter int NUM_IDS = 64,
    parameter int LIM_W   = 12
) (
    input  logic [NUM_IDS-1:0] pend_i,
    input  logic [NUM_IDS-1:0] enab_i,
    input  logic [LIM_W-1:0]   limit_i,
    output logic [NUM_IDS-1:0] qual_o
);
    for (genvar i = 0; i < NUM_IDS; i++) begin : g_id
        if (i == 0) begin : g_zero
            assign qual_o[i] = 1'b0;
        end else begin : g_live
            assign qual_o[i] = pend_i[i] & enab_i[i] & (LIM_W'(i) < limit_i);
        end
    end
endmodule

// File: rtl/tsel_prio_enc.sv
module tsel_prio_enc #(
    parameter int N   = 64,
    parameter int IDW = 11
) (
    input  logic [N-1:0]   req_i,
    output logic           vld_o,
    output logic [IDW-1:0] idx_o
);
    always_comb begin
        vld_o = 1'b0;
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                vld_o = 1'b1;
                idx_o = IDW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_top_sel.sv
module irq_top_sel
    import tsel_pkg::*;
#(
    parameter int NUM_IDS = 64
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_IDS-1:0] pend_i,
    input  logic [NUM_IDS-1:0] enab_i,
    input  logic [1:0]         acc_sel_i,
    input  logic               acc_wr_i,
    input  logic [DATA_W-1:0]  acc_wdata_i,
    input  logic [DATA_W-1:0]  acc_wmask_i,
    output logic [DATA_W-1:0]  acc_rdata_o,
    output logic [DATA_W-1:0]  top_o,
    output logic               clr_vld_o,
    output logic [ID_W-1:0]    clr_id_o,
    output logic               irq_o
);
    localparam int LIM_W = ID_W + 1;
    localparam logic [LIM_W-1:0] ALL_IDS = LIM_W'(NUM_IDS);

    sel_state_t cur_q, nxt_d;

    logic [LIM_W-1:0]   limit_d;
    logic [NUM_IDS-1:0] qual_d;
    logic               win_vld_d;
    logic [ID_W-1:0]    win_id_d;
    logic               unused_wdata;

    assign unused_wdata = ^acc_wdata_i[DATA_W-1:ID_W];

    always_comb begin
        if ((cur_q.thr != '0) && ({1'b0, cur_q.thr} <= ALL_IDS)) begin
            limit_d = {1'b0, cur_q.thr};
        end else begin
            limit_d = ALL_IDS;
        end
    end

    tsel_qual #(
        .NUM_IDS (NUM_IDS),
        .LIM_W   (LIM_W)
    ) u_qual (
        .pend_i  (pend_i),
        .enab_i  (enab_i),
        .limit_i (limit_d),
        .qual_o  (qual_d)
    );

    tsel_prio_enc #(
        .N   (NUM_IDS),
        .IDW (ID_W)
    ) u_enc (
        .req_i (qual_d),
        .vld_o (win_vld_d),
        .idx_o (win_id_d)
    );

    always_comb begin
        nxt_d       = cur_q;
        top_o       = '0;
        acc_rdata_o = '0;
        clr_vld_o   = 1'b0;
        clr_id_o    = win_id_d;

        if (win_vld_d) begin
            top_o[ID_W-1:0]              = win_id_d;
            top_o[PRIO_LSB +: ID_W]      = win_id_d;
        end

        unique case (acc_sel_i)
            SEL_DLV: acc_rdata_o = {{(DATA_W-1){1'b0}}, cur_q.dlv};
            SEL_THR: acc_rdata_o = {{(DATA_W-ID_W){1'b0}}, cur_q.thr};
            SEL_TOP: acc_rdata_o = top_o;
            default: acc_rdata_o = '0;
        endcase

        if (acc_wr_i) begin
            unique case (acc_sel_i)
                SEL_DLV: begin
                    if (acc_wmask_i[0]) begin
                        nxt_d.dlv = acc_wdata_i[0];
                    end
                end
                SEL_THR: begin
                    nxt_d.thr = (cur_q.thr & ~acc_wmask_i[ID_W-1:0]) |
                                (acc_wdata_i[ID_W-1:0] & acc_wmask_i[ID_W-1:0]);
                end
                SEL_TOP: begin
                    clr_vld_o = win_vld_d && (acc_wmask_i != '0);
                end
                default: ;
            endcase
        end

        nxt_d.irq = cur_q.dlv && win_vld_d;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign irq_o = cur_q.irq;
endmodule

// File: rtl/tsel_chk.sv
module tsel_chk
    import tsel_pkg::*;
#(
    parameter int NUM_IDS = 64
) (
    input logic               clk_i,
    input logic               rst_ni,
    input logic [NUM_IDS-1:0] pend_i,
    input logic [NUM_IDS-1:0] enab_i,
    input logic [1:0]         acc_sel_i,
    input logic               acc_wr_i,
    input logic [DATA_W-1:0]  acc_wmask_i,
    input logic [DATA_W-1:0]  top_o,
    input logic               clr_vld_o,
    input logic [ID_W-1:0]    clr_id_o,
    input logic               irq_o,
    input logic               dlv_i,
    input logic [ID_W-1:0]    thr_i
);
    logic [ID_W-1:0] top_id;
    logic            win_both_set;

    assign top_id = top_o[ID_W-1:0];

    always_comb begin
        win_both_set = 1'b0;
        for (int i = 0; i < NUM_IDS; i++) begin
            if (top_id == ID_W'(i)) begin
                win_both_set = pend_i[i] & enab_i[i];
            end
        end
    end

    // R2: a reported winner has both of its bits set; R1: it is never id 0
    a_r2_winner_qualifies: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (top_o != '0) |-> (win_both_set && top_id != '0));

    // R5: two identical copies, nothing else set
    a_r5_fields_match: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (top_o[PRIO_LSB +: ID_W] == top_id) &&
        (top_o[PRIO_LSB-1:ID_W] == '0) &&
        (top_o[DATA_W-1:PRIO_LSB+ID_W] == '0));

    // R3: an active threshold bounds the winner from above
    a_r3_below_threshold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((top_o != '0) && (thr_i != '0) && ({1'b0, thr_i} <= (ID_W+1)'(NUM_IDS)))
        |-> (top_id < thr_i));

    // R6: a claim strobe names the current winner and needs a top write
    a_r6_claim_names_winner: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_vld_o |-> (acc_wr_i && acc_sel_i == SEL_TOP && clr_id_o == top_id && top_id != '0));

    // R7: a zero mask never claims
    a_r7_zero_mask_no_claim: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_wmask_i == '0) |-> !clr_vld_o);

    // R8: registered request line
    a_r8_irq_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> (irq_o == $past(dlv_i && (top_o != '0))));
endmodule

bind irq_top_sel tsel_chk #(
    .NUM_IDS (NUM_IDS)
) u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .pend_i      (pend_i),
    .enab_i      (enab_i),
    .acc_sel_i   (acc_sel_i),
    .acc_wr_i    (acc_wr_i),
    .acc_wmask_i (acc_wmask_i),
    .top_o       (top_o),
    .clr_vld_o   (clr_vld_o),
    .clr_id_o    (clr_id_o),
    .irq_o       (irq_o),
    .dlv_i       (cur_q.dlv),
    .thr_i       (cur_q.thr)
);

// File: tb/irq_top_sel_tb.sv
`timescale 1ns/1ps
module irq_top_sel_tb;
    localparam int N = 64;

    logic          clk_i = 1'b0;
    logic          rst_ni = 1'b0;
    logic [N-1:0]  pend_i = '0;
    logic [N-1:0]  enab_i = '0;
    logic [1:0]    acc_sel_i = 2'd3;
    logic          acc_wr_i = 1'b0;
    logic [31:0]   acc_wdata_i = '0;
    logic [31:0]   acc_wmask_i = '0;
    logic [31:0]   acc_rdata_o;
    logic [31:0]   top_o;
    logic          clr_vld_o;
    logic [10:0]   clr_id_o;
    logic          irq_o;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk_i = ~clk_i;

    irq_top_sel #(.NUM_IDS(N)) u_dut (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .pend_i      (pend_i),
        .enab_i      (enab_i),
        .acc_sel_i   (acc_sel_i),
        .acc_wr_i    (acc_wr_i),
        .acc_wdata_i (acc_wdata_i),
        .acc_wmask_i (acc_wmask_i),
        .acc_rdata_o (acc_rdata_o),
        .top_o       (top_o),
        .clr_vld_o   (clr_vld_o),
        .clr_id_o    (clr_id_o),
        .irq_o       (irq_o)
    );

    function automatic logic [31:0] topv(input int id);
        return (32'(id) << 16) | 32'(id);
    endfunction

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic set_bits(input logic [N-1:0] p, input logic [N-1:0] e);
        @(negedge clk_i);
        pend_i = p;
        enab_i = e;
        #1;
    endtask

    // Drive one write for one cycle; returns the read value seen before commit.
    task automatic wr(input logic [1:0] sel, input logic [31:0] d,
                      input logic [31:0] m, output logic [31:0] old);
        @(negedge clk_i);
        acc_sel_i = sel; acc_wr_i = 1'b1; acc_wdata_i = d; acc_wmask_i = m;
        #1;
        old = acc_rdata_o;
        @(posedge clk_i);
        @(negedge clk_i);
        acc_wr_i = 1'b0; acc_sel_i = 2'd3; acc_wdata_i = '0; acc_wmask_i = '0;
        #1;
    endtask

    task automatic rd(input logic [1:0] sel, output logic [31:0] v);
        acc_sel_i = sel;
        #1;
        v = acc_rdata_o;
        acc_sel_i = 2'd3;
        #1;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(2'd0, v); chk(v, 32'd0, "R11 delivery after reset");
        rd(2'd1, v); chk(v, 32'd0, "R11 threshold after reset");
        chk({31'd0, irq_o}, 32'd0, "R11 irq after reset");
        chk(top_o, 32'd0, "R5 top zero when empty");
    endtask

    task automatic t_id_zero();
        set_bits(64'h1, 64'h1);
        chk(top_o, 32'd0, "R1 id0 alone not selected");
        set_bits('1, '1);
        chk(top_o, topv(1), "R1 all set picks id1");
    endtask

    task automatic t_qualify();
        set_bits((64'd1 << 5) | (64'd1 << 9), 64'd1 << 9);
        chk(top_o, topv(9), "R2 needs both bits");
        set_bits((64'd1 << 3) | (64'd1 << 7), (64'd1 << 3) | (64'd1 << 7));
        chk(top_o, topv(3), "R2 lowest wins");
        chk(top_o & 32'hF800_F800, 32'd0, "R5 spare bits zero");
        set_bits(64'd1 << 12, 64'd1 << 13);
        chk(top_o, 32'd0, "R2 disjoint bits no winner");
    endtask

    task automatic t_thresh();
        logic [31:0] old, v;
        set_bits((64'd1 << 10) | (64'd1 << 20), (64'd1 << 10) | (64'd1 << 20));
        wr(2'd1, 32'd10, '1, old);
        chk(top_o, 32'd0, "R3 threshold equal id excludes it");
        wr(2'd1, 32'd11, '1, old);
        chk(old, 32'd10, "R10 read returns old threshold");
        chk(top_o, topv(10), "R3 threshold above id");
        set_bits(64'd1 << 63, 64'd1 << 63);
        wr(2'd1, 32'd63, '1, old);
        chk(top_o, 32'd0, "R3 threshold 63 excludes 63");
        wr(2'd1, 32'd64, '1, old);
        chk(top_o, topv(63), "R3 threshold equal count");
        wr(2'd1, 32'd0, '1, old);
        chk(top_o, topv(63), "R4 zero threshold searches all");
        wr(2'd1, 32'd65, '1, old);
        chk(top_o, topv(63), "R4 threshold past count searches all");
        wr(2'd1, 32'hFFFF_FFFF, '1, old);
        rd(2'd1, v); chk(v, 32'h7FF, "R10 threshold width masked");
        wr(2'd1, 32'd0, 32'h1, old);
        rd(2'd1, v); chk(v, 32'h7FE, "R10 per-bit mask");
        chk(top_o, topv(63), "R4 large threshold all ids");
        wr(2'd1, 32'd0, '1, old);
    endtask

    task automatic t_claim();
        logic [31:0] old;
        set_bits((64'd1 << 4) | (64'd1 << 6), (64'd1 << 4) | (64'd1 << 6));
        @(negedge clk_i);
        acc_sel_i = 2'd2; acc_wr_i = 1'b1; acc_wdata_i = 32'd0; acc_wmask_i = 32'h1;
        #1;
        chk({31'd0, clr_vld_o}, 32'd1, "R6 claim strobe");
        chk({21'd0, clr_id_o}, 32'd4, "R6 claim id");
        acc_wdata_i = 32'd6;
        #1;
        chk({21'd0, clr_id_o}, 32'd4, "R6 data ignored");
        acc_wmask_i = 32'h0;
        #1;
        chk({31'd0, clr_vld_o}, 32'd0, "R7 zero mask no claim");
        acc_wmask_i = 32'hFFFF_FFFF;
        pend_i = '0;
        #1;
        chk({31'd0, clr_vld_o}, 32'd0, "R7 no winner no claim");
        acc_sel_i = 2'd3;
        pend_i = 64'd1 << 4;
        #1;
        chk({31'd0, clr_vld_o}, 32'd0, "R11 idle select no claim");
        chk(acc_rdata_o, 32'd0, "R11 idle select reads zero");
        acc_wr_i = 1'b0; acc_wmask_i = '0; acc_wdata_i = '0;
        wr(2'd2, 32'd55, '1, old);
        chk(top_o, topv(4), "R6 top write stores nothing");
    endtask

    task automatic t_irq();
        logic [31:0] old, v;
        set_bits(64'd1 << 5, 64'd1 << 5);
        wr(2'd0, 32'hFFFF_FFFF, '1, old);
        chk(old, 32'd0, "R9 old delivery value");
        chk({31'd0, irq_o}, 32'd0, "R8 irq lags one cycle");
        @(negedge clk_i); #1;
        chk({31'd0, irq_o}, 32'd1, "R8 irq raised");
        rd(2'd0, v); chk(v, 32'd1, "R9 only bit0 stored");
        wr(2'd0, 32'd0, 32'hFFFF_FFFE, old);
        rd(2'd0, v); chk(v, 32'd1, "R9 masked bit0 kept");
        wr(2'd3, 32'd0, '1, old);
        rd(2'd0, v); chk(v, 32'd1, "R11 idle write no effect");
        set_bits('0, 64'd1 << 5);
        chk({31'd0, irq_o}, 32'd1, "R8 irq still old value");
        @(negedge clk_i); #1;
        chk({31'd0, irq_o}, 32'd0, "R8 irq drops");
        set_bits(64'd1 << 5, 64'd1 << 5);
        wr(2'd0, 32'd0, 32'h1, old);
        @(negedge clk_i); #1;
        chk({31'd0, irq_o}, 32'd0, "R8 delivery off masks irq");
    endtask

    initial begin
        #(4 * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        #1;
        t_reset();
        t_id_zero();
        t_qualify();
        t_thresh();
        t_claim();
        t_irq();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule